// File: doc/BRIEF.md
# Variable-Length Word Packer

This block gathers variable-length records into fixed 512-bit output words for a downstream FIFO. A record arrives every clock cycle. It is a lane vector of up to 40 sixteen-bit words plus a count of how many leading lanes are valid. The packer appends the valid words behind whatever it already holds. When it holds at least 32 words, it writes the oldest 32 as one output word. The words that did not fit move to the front of the hold register in that same cycle.

There is no ready signal on the input, so the packer never stalls. The upstream side must keep the sustained word rate at or below one output word per cycle, so that the held count plus the incoming count never exceeds the hold capacity of 71 words. The FIFO is assumed never to be full. If a write does land while the FIFO reports full, a sticky flag records it.

Top module: `vlw_packer`

## Requirements
- R1: A synchronous active-high reset empties the hold register and clears `fifo_wr_en` and `fifo_ovf`. No word received before the reset appears in any later output word.
- R2: Words keep their arrival order. Output lane j, bits [16j+15:16j], carries the j-th oldest held word. Lane i of `in_data`, bits [16i+15:16i], is the i-th word of its record.
- R3: When held plus incoming words reach 32 or more, `fifo_wr_en` is high for exactly the cycle after that record's clock edge, and `fifo_wr_data` carries the 32 oldest words. Otherwise `fifo_wr_en` is low.
- R4: The words beyond the emitted 32 are kept at the front of the hold register in the same cycle. They lead the next output word, and no word is lost or duplicated.
- R5: A record with `in_count` = 0, arriving while fewer than 32 words are held, leaves the held words unchanged and produces no write.
- R6: Lanes at index `in_count` or above are ignored, whatever their contents.
- R7: A record is accepted on every clock edge. Back-to-back full 32-word records produce a write on every cycle.
- R8: If `fifo_wr_en` and `fifo_full` are both high at a clock edge, `fifo_ovf` is high from the next cycle until reset.
- R9: `in_count` never exceeds 40, and the held count stays within 71 words under the stated input rate rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_count | input | 6 | Number of valid leading lanes in `in_data` (0 to 40) |
| in_data | input | 640 | Record lanes, 40 x 16 bits, lane 0 in the low bits |
| fifo_full | input | 1 | Downstream FIFO full indication |
| fifo_wr_en | output | 1 | One-cycle write strobe for each packed word |
| fifo_wr_data | output | 512 | Packed output word, oldest word in the low bits |
| fifo_ovf | output | 1 | Sticky flag: a write occurred while the FIFO was full |

## Verification
The bench aims at several boundaries. One is a record that brings the held count to exactly 32, where a design using the wrong comparison would either miss the write or leave a stale word behind. Another is a record that straddles the 32-word boundary: if the carry to the front were wrong, the next output would show shifted, duplicated or missing words. A third is the largest 40-word record arriving on a partly full buffer. The bench also fills the unused lanes with nonzero junk, which would corrupt later words if the lane masking were missing. Finally, it covers a zero-length record, a reset in the middle of filling, and a write into a full FIFO. These catch a leaky reset, a spurious write, and a flag that either fails to stick or is never raised.

// File: rtl/vlw_pkg.sv
package vlw_pkg;
  localparam int unsigned WORD_W_DEF    = 16;
  localparam int unsigned OUT_WORDS_DEF = 32;
  localparam int unsigned REC_WORDS_DEF = 40;
endpackage

// File: rtl/vlw_merge.sv
module vlw_merge #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CAP_WORDS = 71,
  parameter int unsigned REC_WORDS = 40,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned RCNT_W    = 6
) (
  input  logic [CAP_WORDS*WORD_W-1:0] held_data,
  input  logic [CNT_W-1:0]            held_cnt,
  input  logic [REC_WORDS*WORD_W-1:0] rec_data,
  input  logic [RCNT_W-1:0]           rec_cnt,
  output logic [CAP_WORDS*WORD_W-1:0] merged,
  output logic [CNT_W-1:0]            total
);
  localparam int unsigned CAP_BITS = CAP_WORDS * WORD_W;
  localparam int unsigned REC_BITS = REC_WORDS * WORD_W;
  localparam int unsigned SH_W     = $clog2(CAP_BITS) + 1;

  logic [REC_BITS-1:0] rec_masked;
  logic [CAP_BITS-1:0] rec_ext;
  logic [SH_W-1:0]     shamt;

  // lanes at or beyond the valid count are forced to zero
  for (genvar i = 0; i < REC_WORDS; i++) begin : g_lane
    assign rec_masked[i*WORD_W +: WORD_W] =
      (RCNT_W'(i) < rec_cnt) ? rec_data[i*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    rec_ext = '0;
    rec_ext[REC_BITS-1:0] = rec_masked;
    shamt   = SH_W'(held_cnt * WORD_W);
    merged  = held_data | (rec_ext << shamt);
    total   = held_cnt + CNT_W'(rec_cnt);
  end
endmodule

// File: rtl/vlw_emit.sv
module vlw_emit #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CAP_WORDS = 71,
  parameter int unsigned OUT_WORDS = 32,
  parameter int unsigned CNT_W     = 7
) (
  input  logic [CAP_WORDS*WORD_W-1:0] merged,
  input  logic [CNT_W-1:0]            total,
  output logic                        emit,
  output logic [OUT_WORDS*WORD_W-1:0] out_word,
  output logic [CAP_WORDS*WORD_W-1:0] rest_data,
  output logic [CNT_W-1:0]            rest_cnt
);
  localparam int unsigned OUT_BITS = OUT_WORDS * WORD_W;

  always_comb begin
    emit     = (total >= CNT_W'(OUT_WORDS));
    out_word = merged[OUT_BITS-1:0];
    if (emit) begin
      rest_data = merged >> OUT_BITS;
      rest_cnt  = total - CNT_W'(OUT_WORDS);
    end else begin
      rest_data = merged;
      rest_cnt  = total;
    end
  end
endmodule

// File: rtl/vlw_packer.sv
module vlw_packer
  import vlw_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned OUT_WORDS = OUT_WORDS_DEF,
  parameter int unsigned REC_WORDS = REC_WORDS_DEF,
  localparam int unsigned CAP_WORDS = OUT_WORDS + REC_WORDS - 1,
  localparam int unsigned CNT_W     = $clog2(CAP_WORDS + 1),
  localparam int unsigned RCNT_W    = $clog2(REC_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [RCNT_W-1:0]           in_count,
  input  logic [REC_WORDS*WORD_W-1:0] in_data,
  input  logic                        fifo_full,
  output logic                        fifo_wr_en,
  output logic [OUT_WORDS*WORD_W-1:0] fifo_wr_data,
  output logic                        fifo_ovf
);
  logic [CAP_WORDS*WORD_W-1:0] held_data, merged, rest_data;
  logic [CNT_W-1:0]            held_cnt, total, rest_cnt;
  logic                        emit;
  logic [OUT_WORDS*WORD_W-1:0] out_word;

  vlw_merge #(
    .WORD_W(WORD_W), .CAP_WORDS(CAP_WORDS), .REC_WORDS(REC_WORDS),
    .CNT_W(CNT_W), .RCNT_W(RCNT_W)
  ) u_merge (
    .held_data(held_data), .held_cnt(held_cnt),
    .rec_data(in_data), .rec_cnt(in_count),
    .merged(merged), .total(total)
  );

  vlw_emit #(
    .WORD_W(WORD_W), .CAP_WORDS(CAP_WORDS), .OUT_WORDS(OUT_WORDS), .CNT_W(CNT_W)
  ) u_emit (
    .merged(merged), .total(total), .emit(emit), .out_word(out_word),
    .rest_data(rest_data), .rest_cnt(rest_cnt)
  );

  // the only state: hold register, output word and strobe, sticky flag
  always_ff @(posedge clk) begin
    if (rst) begin
      held_data    <= '0;
      held_cnt     <= '0;
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      fifo_ovf     <= 1'b0;
    end else begin
      held_data  <= rest_data;
      held_cnt   <= rest_cnt;
      fifo_wr_en <= emit;
      if (emit) fifo_wr_data <= out_word;
      fifo_ovf   <= fifo_ovf | (fifo_wr_en & fifo_full);
    end
  end

  AST_REC_MAX: assert property (@(posedge clk) disable iff (rst)
    in_count <= RCNT_W'(REC_WORDS)); // R9
  AST_HELD_CAP: assert property (@(posedge clk) disable iff (rst)
    held_cnt <= CNT_W'(CAP_WORDS)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (held_cnt + (fifo_wr_en ? CNT_W'(OUT_WORDS) : '0)
                     == $past(held_cnt) + CNT_W'($past(in_count)))); // R4
  AST_EMPTY_REC: assert property (@(posedge clk) disable iff (rst)
    (in_count == '0 && held_cnt < CNT_W'(OUT_WORDS))
      |=> (!fifo_wr_en && $stable(held_cnt) && $stable(held_data))); // R5
  AST_WR_THRESH: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> $past(held_cnt) + CNT_W'($past(in_count))
                   >= CNT_W'(OUT_WORDS)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr_en && fifo_full) |=> fifo_ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> fifo_ovf); // R8
endmodule

// File: tb/vlw_packer_tb.sv
module vlw_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, OW = 32, RW = 40;
  localparam int VEC_N = 12;
  localparam int VCNT [VEC_N] = '{20, 20, 0, 32, 5, 27, 40, 0, 31, 1, 16, 16};
  localparam bit VWR  [VEC_N] = '{0,  1,  0, 1,  0, 1,  1,  0, 1,  0, 1,  0};

  logic clk = 1'b0, rst = 1'b1, fifo_full = 1'b0;
  logic [5:0] in_count = '0;
  logic [RW*W-1:0] in_data = '0;
  logic fifo_wr_en, fifo_ovf;
  logic [OW*W-1:0] fifo_wr_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mq [0:127];
  int mcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlw_packer u_dut (
    .clk(clk), .rst(rst), .in_count(in_count), .in_data(in_data),
    .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_ovf(fifo_ovf)
  );

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_word(string req);
    logic [OW*W-1:0] exp;
    for (int j = 0; j < OW; j++) exp[j*W +: W] = mq[j];
    checks++;
    if (fifo_wr_data !== exp) begin
      fails++;
      $display("FAIL %s: data %h expected %h", req, fifo_wr_data, exp);
    end
    for (int j = 0; j < mcnt - OW; j++) mq[j] = mq[j+OW];
    mcnt -= OW;
  endtask

  // drive one record at a falling edge, check the result one edge later
  task automatic step(int cnt, bit junk, logic [7:0] tag, string req, output bit wr);
    for (int k = 0; k < RW; k++)
      in_data[k*W +: W] = (k < cnt) ? {tag, 8'(k)} : (junk ? 16'hDEAD : 16'h0000);
    in_count = 6'(cnt);
    for (int k = 0; k < cnt; k++) mq[mcnt+k] = {tag, 8'(k)};
    mcnt += cnt;
    @(posedge clk); @(negedge clk);
    wr = (mcnt >= OW);
    chk_bit(req, fifo_wr_en, wr);
    if (wr) chk_word(req);
    in_count = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expired expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit wr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_bit("R1 wr_en at reset", fifo_wr_en, 1'b0);
    chk_bit("R1 ovf at reset", fifo_ovf, 1'b0);
    rst = 1'b0;

    // table walk: R2 R3 R4 R5 R6 (junk in unused lanes on odd entries)
    for (int v = 0; v < VEC_N; v++) begin
      step(VCNT[v], v[0], 8'(8'h10 + v), "R2/R3/R4/R6 table", wr);
      chk_bit("R3 table expected strobe", wr, VWR[v]);
    end

    // R5: empty record on a partly filled buffer, then check order survives
    step(10, 1'b1, 8'h40, "R5 fill", wr);
    step(0, 1'b1, 8'h41, "R5 empty record no write", wr);
    step(22, 1'b0, 8'h42, "R5 order after empty record", wr);

    // R7: back-to-back full records write every cycle
    for (int n = 0; n < 4; n++) step(32, 1'b1, 8'(8'h50 + n), "R7 back-to-back", wr);

    // R4: largest record straddling boundary, carried words lead next word
    step(40, 1'b0, 8'h60, "R4 max record", wr);
    step(24, 1'b0, 8'h61, "R4 carry leads", wr);

    // R1: reset mid-fill discards held words
    step(12, 1'b0, 8'h70, "R1 prefill", wr);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    mcnt = 0;
    chk_bit("R1 wr_en after reset", fifo_wr_en, 1'b0);
    step(32, 1'b0, 8'h71, "R1 only new words", wr);

    // R8: write while full raises sticky flag
    chk_bit("R8 flag clear before", fifo_ovf, 1'b0);
    fifo_full = 1'b1;
    step(32, 1'b0, 8'h80, "R8 write into full", wr);
    @(posedge clk); @(negedge clk);
    fifo_full = 1'b0;
    chk_bit("R8 flag set", fifo_ovf, 1'b1);
    repeat (3) @(negedge clk);
    chk_bit("R8 flag sticky", fifo_ovf, 1'b1);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    chk_bit("R1 reset clears flag", fifo_ovf, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule